// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control sequencer of a small accumulator processor whose 16-bit instruction word carries a 2-bit addressing mode in bits [15:14], a 4-bit operation code in bits [13:10] and a 10-bit address or data field in bits [9:0]. It works through five major cycles: fetch, indirect, direct, execute and interrupt. Three cycle flip-flops select the major cycle. A 2-bit step counter names the timing pulse T0 to T3 inside that cycle.

At each step the block drives the register-transfer strobes for that step. It also holds the address-side registers: program counter, memory address register, memory buffer, address register, mode bits and operation register. It branches on the addressing mode at the end of fetch and on the interrupt request at the end of execute.

The instruction-specific work of the execute cycle stays outside the block. It is delimited by two inputs:
- `exec_long` marks an instruction that needs more than one step.
- `exec_done` ends such an instruction.

Memory is external and reads combinationally at `mem_addr`.

The state machine has these states (`cyc_state`):
- `CY_FETCH` = 000
- `CY_IND` = 001
- `CY_DIR` = 010
- `CY_EXEC` = 011
- `CY_INTR` = 100

It has these transitions:
- fetch→indirect, fetch→direct and fetch→execute, taken at fetch T3.
- indirect→direct, taken at T3.
- direct→execute, taken at T2.
- execute→interrupt and execute→fetch, taken when execute finishes.
- interrupt→fetch, taken at T3.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `cyc_state` is 000 (fetch), `tstep` is 0 and `pc` is 0.
- R2: `cyc_state` encodes the major cycle as 000 fetch, 001 indirect, 010 direct, 011 execute and 100 interrupt. No other code ever appears.
- R3: `tstep` returns to 0 in the first step of every new major cycle. Within a cycle it counts up by one per clock.
- R4: Fetch takes four steps:
  - T0: `ld_mar` is high and MAR takes PC.
  - T1: `mem_rd` is high at `mem_addr`=PC, MBR takes `mem_rdata` and `pc_inc` advances PC.
  - T2: `ld_opr` and `ld_ar` load `mode`=MBR[15:14], `opr`=MBR[13:10] and `ar`=MBR[9:0].
  - T3: the branch is taken.
- R5: At fetch T3 the next cycle is chosen from the mode bits:
  - Mode 11 with an operation code other than 1111 goes to indirect.
  - Mode 01 goes to direct.
  - Mode 00, mode 10 and I/O instructions (mode 11 with code 1111) go straight to execute.
- R6: Indirect takes four steps:
  - T0: MAR takes AR.
  - T1: memory is read into MBR.
  - T2: AR takes MBR[9:0].
  - T3: the sequencer moves to direct.
- R7: Direct takes three steps and then goes to execute T0:
  - T0: MAR takes AR.
  - T1: memory is read into MBR.
  - T2: the step counter is cleared.
- R8: Execute sets `exec_active`. With `exec_long`=0 it finishes after T0. With `exec_long`=1 it finishes at the step in which `exec_done` is 1.
- R9: When execute finishes, the next cycle is interrupt if `int_req` is 1 and fetch otherwise.
- R10: Interrupt takes four steps and then returns to fetch:
  - T0: MBR takes the zero-extended PC and `int_ack` pulses.
  - T1: PC and MAR are cleared.
  - T2: `mem_wr` writes MBR to address 0 and PC becomes 1.
- R11: `is_rri` is 1 exactly when `opr`=1111 and `mode`=00. `is_ioi` is 1 exactly when `opr`=1111 and `mode`=11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 16 | Memory read data at `mem_addr` |
| int_req | input | 1 | Interrupt flip-flop level |
| exec_long | input | 1 | Current instruction needs more than one execute step |
| exec_done | input | 1 | Multi-step execute has finished |
| mem_addr | output | 10 | Memory address (MAR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (MBR) |
| cyc_state | output | 3 | Major cycle code |
| tstep | output | 2 | Timing step T0..T3 |
| pc | output | 10 | Program counter |
| ar | output | 10 | Address register |
| opr | output | 4 | Operation register |
| mode | output | 2 | Addressing mode bits |
| is_rri | output | 1 | Register-reference instruction decoded |
| is_ioi | output | 1 | I/O instruction decoded |
| exec_active | output | 1 | Execute cycle in progress |
| int_ack | output | 1 | Clear the interrupt flip-flop |
| ld_mar | output | 1 | MAR load strobe |
| ld_mbr | output | 1 | MBR load strobe |
| ld_ar | output | 1 | AR load strobe |
| ld_opr | output | 1 | Operation register and mode load strobe |
| pc_inc | output | 1 | PC increment strobe |
| pc_clr | output | 1 | PC clear strobe |

## Verification
The bench walks the direct cycle step by step. A sequencer that ignored the early exit at T2 would show direct T3 instead of execute T0 one clock later.

An I/O instruction carries mode 11. A decoder that looked only at the mode bits would send it into the indirect cycle.

The bench drives a multi-step execute that ends at T2, which would reveal a sequencer that stopped after T0 or ignored `exec_done`. It also checks that the interrupt path writes the return address to location 0 and resumes at location 1. A wrong PC clear or increment there would resume at 0 or 2.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        CY_FETCH = 3'b000,
        CY_IND   = 3'b001,
        CY_DIR   = 3'b010,
        CY_EXEC  = 3'b011,
        CY_INTR  = 3'b100
    } cyc_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ar;
        logic mar_clr;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic pc_inc;
        logic pc_clr;
        logic ar_load;
        logic ir_load;
        logic mem_rd;
        logic mem_wr;
        logic int_ack;
    } strobe_t;

endpackage

// File: rtl/seq_timing.sv
module seq_timing #(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic [STEP_W-1:0] tstep
);
    logic [STEP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    assign tstep = cnt_q;

    AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q == STEP_W'($past(cnt_q) + 1'b1))); // R3
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] tstep,
    input  logic [1:0]        mode,
    input  logic              is_ioi,
    input  logic              exec_long,
    input  logic              exec_done,
    input  logic              int_req,
    output cyc_e              cyc_q,
    output logic              cyc_change,
    output strobe_t           stb
);
    localparam logic [STEP_W-1:0] T0 = STEP_W'(0);
    localparam logic [STEP_W-1:0] T1 = STEP_W'(1);
    localparam logic [STEP_W-1:0] T2 = STEP_W'(2);
    localparam logic [STEP_W-1:0] T3 = STEP_W'(3);

    cyc_e cyc_d;
    logic exec_fin;

    assign exec_fin = exec_long ? exec_done : (tstep == T0);

    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= CY_FETCH;
        else        cyc_q <= cyc_d;
    end

    always_comb begin
        cyc_d = cyc_q;
        unique case (cyc_q)
            CY_FETCH: begin
                if (tstep == T3) begin
                    if (mode == 2'b11 && !is_ioi) cyc_d = CY_IND;
                    else if (mode == 2'b01)       cyc_d = CY_DIR;
                    else                          cyc_d = CY_EXEC;
                end
            end
            CY_IND:   if (tstep == T3) cyc_d = CY_DIR;
            CY_DIR:   if (tstep == T2) cyc_d = CY_EXEC;
            CY_EXEC:  if (exec_fin) cyc_d = int_req ? CY_INTR : CY_FETCH;
            CY_INTR:  if (tstep == T3) cyc_d = CY_FETCH;
            default:  cyc_d = CY_FETCH;
        endcase
    end

    assign cyc_change = (cyc_d != cyc_q);

    always_comb begin
        stb = '0;
        unique case (cyc_q)
            CY_FETCH: begin
                if (tstep == T0) stb.mar_from_pc = 1'b1;
                if (tstep == T1) begin
                    stb.mem_rd       = 1'b1;
                    stb.mbr_from_mem = 1'b1;
                    stb.pc_inc       = 1'b1;
                end
                if (tstep == T2) begin
                    stb.ir_load = 1'b1;
                    stb.ar_load = 1'b1;
                end
            end
            CY_IND: begin
                if (tstep == T0) stb.mar_from_ar = 1'b1;
                if (tstep == T1) begin
                    stb.mem_rd       = 1'b1;
                    stb.mbr_from_mem = 1'b1;
                end
                if (tstep == T2) stb.ar_load = 1'b1;
            end
            CY_DIR: begin
                if (tstep == T0) stb.mar_from_ar = 1'b1;
                if (tstep == T1) begin
                    stb.mem_rd       = 1'b1;
                    stb.mbr_from_mem = 1'b1;
                end
            end
            CY_EXEC: ;
            CY_INTR: begin
                if (tstep == T0) begin
                    stb.mbr_from_pc = 1'b1;
                    stb.int_ack     = 1'b1;
                end
                if (tstep == T1) begin
                    stb.pc_clr  = 1'b1;
                    stb.mar_clr = 1'b1;
                end
                if (tstep == T2) begin
                    stb.mem_wr = 1'b1;
                    stb.pc_inc = 1'b1;
                end
            end
            default: ;
        endcase
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q inside {CY_FETCH, CY_IND, CY_DIR, CY_EXEC, CY_INTR})); // R2
    AST_DIR_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_DIR && tstep == T2) |=> (cyc_q == CY_EXEC)); // R7
    AST_IND_TO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_IND && tstep == T3) |=> (cyc_q == CY_DIR)); // R6
    AST_EXEC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_EXEC && exec_fin && int_req) |=> (cyc_q == CY_INTR)); // R9
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb.mem_rd && stb.mem_wr)); // R10
endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter int AW  = 10,
    parameter int OPW = 4,
    parameter int MW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           stb,
    input  logic [MW+OPW+AW-1:0] mem_rdata,
    output logic [AW-1:0]     pc_q,
    output logic [AW-1:0]     mar_q,
    output logic [MW+OPW+AW-1:0] mbr_q,
    output logic [AW-1:0]     ar_q,
    output logic [OPW-1:0]    opr_q,
    output logic [MW-1:0]     mode_q,
    output logic              is_rri,
    output logic              is_ioi
);
    localparam int DW = MW + OPW + AW;
    localparam logic [OPW-1:0] OP_SPECIAL = {OPW{1'b1}};
    localparam logic [MW-1:0]  MODE_IMM   = '0;
    localparam logic [MW-1:0]  MODE_IND   = {MW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= '0;
        else if (stb.pc_clr) pc_q <= '0;
        else if (stb.pc_inc) pc_q <= pc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               mar_q <= '0;
        else if (stb.mar_clr)     mar_q <= '0;
        else if (stb.mar_from_pc) mar_q <= pc_q;
        else if (stb.mar_from_ar) mar_q <= ar_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                mbr_q <= '0;
        else if (stb.mbr_from_mem) mbr_q <= mem_rdata;
        else if (stb.mbr_from_pc)  mbr_q <= {{(DW-AW){1'b0}}, pc_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q   <= '0;
            opr_q  <= '0;
            mode_q <= '0;
        end else begin
            if (stb.ar_load) ar_q <= mbr_q[AW-1:0];
            if (stb.ir_load) begin
                opr_q  <= mbr_q[AW +: OPW];
                mode_q <= mbr_q[DW-1 -: MW];
            end
        end
    end

    assign is_rri = (opr_q == OP_SPECIAL) && (mode_q == MODE_IMM);
    assign is_ioi = (opr_q == OP_SPECIAL) && (mode_q == MODE_IND);

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.pc_inc && !stb.pc_clr) |=> (pc_q == AW'($past(pc_q) + 1'b1))); // R4
    AST_PC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        stb.pc_clr |=> (pc_q == '0)); // R10
    AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_rri && is_ioi)); // R11
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import seq_pkg::*;
#(
    parameter int AW     = 10,
    parameter int OPW    = 4,
    parameter int MW     = 2,
    parameter int STEP_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MW+OPW+AW-1:0]  mem_rdata,
    input  logic                  int_req,
    input  logic                  exec_long,
    input  logic                  exec_done,
    output logic [AW-1:0]         mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [MW+OPW+AW-1:0]  mem_wdata,
    output logic [2:0]            cyc_state,
    output logic [STEP_W-1:0]     tstep,
    output logic [AW-1:0]         pc,
    output logic [AW-1:0]         ar,
    output logic [OPW-1:0]        opr,
    output logic [MW-1:0]         mode,
    output logic                  is_rri,
    output logic                  is_ioi,
    output logic                  exec_active,
    output logic                  int_ack,
    output logic                  ld_mar,
    output logic                  ld_mbr,
    output logic                  ld_ar,
    output logic                  ld_opr,
    output logic                  pc_inc,
    output logic                  pc_clr
);
    localparam int DW = MW + OPW + AW;

    cyc_e    cyc_q;
    logic    cyc_change;
    strobe_t stb;
    logic [AW-1:0] mar_q;
    logic [DW-1:0] mbr_q;

    seq_timing #(.STEP_W(STEP_W)) u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cyc_change),
        .tstep (tstep)
    );

    seq_fsm #(.STEP_W(STEP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tstep      (tstep),
        .mode       (mode),
        .is_ioi     (is_ioi),
        .exec_long  (exec_long),
        .exec_done  (exec_done),
        .int_req    (int_req),
        .cyc_q      (cyc_q),
        .cyc_change (cyc_change),
        .stb        (stb)
    );

    seq_regs #(.AW(AW), .OPW(OPW), .MW(MW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb),
        .mem_rdata (mem_rdata),
        .pc_q      (pc),
        .mar_q     (mar_q),
        .mbr_q     (mbr_q),
        .ar_q      (ar),
        .opr_q     (opr),
        .mode_q    (mode),
        .is_rri    (is_rri),
        .is_ioi    (is_ioi)
    );

    assign mem_addr    = mar_q;
    assign mem_wdata   = mbr_q;
    assign mem_rd      = stb.mem_rd;
    assign mem_wr      = stb.mem_wr;
    assign cyc_state   = cyc_q;
    assign exec_active = (cyc_q == CY_EXEC);
    assign int_ack     = stb.int_ack;
    assign ld_mar      = stb.mar_from_pc | stb.mar_from_ar | stb.mar_clr;
    assign ld_mbr      = stb.mbr_from_mem | stb.mbr_from_pc;
    assign ld_ar       = stb.ar_load;
    assign ld_opr      = stb.ir_load;
    assign pc_inc      = stb.pc_inc;
    assign pc_clr      = stb.pc_clr;

    AST_STEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != $past(cyc_q)) |-> (tstep == '0)); // R3
    AST_WR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == '0 && cyc_q == CY_INTR)); // R10
    AST_FETCH_MAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_FETCH && tstep == '0) |=> (mem_addr == $past(pc))); // R4
endmodule

// File: tb/sim_instr_cycle_seq.sv
module sim_instr_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_rdata;
    logic        int_req = 1'b0;
    logic        exec_long = 1'b0;
    logic        exec_done = 1'b0;
    logic [9:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [2:0]  cyc_state;
    logic [1:0]  tstep;
    logic [9:0]  pc, ar;
    logic [3:0]  opr;
    logic [1:0]  mode;
    logic        is_rri, is_ioi, exec_active, int_ack;
    logic        ld_mar, ld_mbr, ld_ar, ld_opr, pc_inc, pc_clr;

    logic [15:0] mem [1024];
    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [2:0] S_F = 3'b000, S_I = 3'b001, S_D = 3'b010,
                           S_E = 3'b011, S_X = 3'b100;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    instr_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .int_req(int_req),
        .exec_long(exec_long), .exec_done(exec_done), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .cyc_state(cyc_state), .tstep(tstep), .pc(pc), .ar(ar), .opr(opr),
        .mode(mode), .is_rri(is_rri), .is_ioi(is_ioi),
        .exec_active(exec_active), .int_ack(int_ack), .ld_mar(ld_mar),
        .ld_mbr(ld_mbr), .ld_ar(ld_ar), .ld_opr(ld_opr), .pc_inc(pc_inc),
        .pc_clr(pc_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic at(input string tag, input logic [2:0] s, input logic [1:0] t);
        chk({tag, " state"}, 32'(cyc_state), 32'(s));
        chk({tag, " step"}, 32'(tstep), 32'(t));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart(input logic [15:0] w0);
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        mem[0] = w0;
        int_req = 1'b0; exec_long = 1'b0; exec_done = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic to_fetch_t3();
        step(); step(); step();
    endtask

    task automatic t_reset();
        restart(16'h0);
        at("R1 reset", S_F, 2'd0);
        chk("R1 pc", 32'(pc), 0);
    endtask

    task automatic t_immediate();
        restart({2'b00, 4'h2, 10'h055});
        at("R4 f0", S_F, 2'd0);
        chk("R4 ld_mar", 32'(ld_mar), 1);
        step();
        at("R4 f1", S_F, 2'd1);
        chk("R4 mem_rd", 32'(mem_rd), 1);
        chk("R4 addr", 32'(mem_addr), 0);
        step();
        at("R3 f2", S_F, 2'd2);
        chk("R4 pc+1", 32'(pc), 1);
        chk("R4 ld_ar", 32'(ld_ar & ld_opr), 1);
        step();
        chk("R4 opr", 32'(opr), 2);
        chk("R4 ar", 32'(ar), 32'h55);
        chk("R4 mode", 32'(mode), 0);
        step();
        at("R5 imm->exec", S_E, 2'd0);
        chk("R8 exec_active", 32'(exec_active), 1);
        step();
        at("R9 back to fetch", S_F, 2'd0);
        chk("R3 pc kept", 32'(pc), 1);
    endtask

    task automatic t_direct();
        restart({2'b01, 4'h3, 10'h100});
        mem[10'h100] = 16'hBEEF;
        to_fetch_t3();
        step();
        at("R5 dir", S_D, 2'd0);
        chk("R7 ld_mar", 32'(ld_mar), 1);
        step();
        at("R7 d1", S_D, 2'd1);
        chk("R7 addr", 32'(mem_addr), 32'h100);
        step();
        at("R7 d2", S_D, 2'd2);
        step();
        at("R7 short exit", S_E, 2'd0);
        chk("R7 mbr", 32'(mem_wdata), 32'hBEEF);
    endtask

    task automatic t_indirect();
        restart({2'b11, 4'h1, 10'h200});
        mem[10'h200] = 16'h0300;
        mem[10'h300] = 16'h1234;
        to_fetch_t3();
        step();
        at("R5 ind", S_I, 2'd0);
        step();
        chk("R6 addr", 32'(mem_addr), 32'h200);
        step();
        chk("R6 ld_ar", 32'(ld_ar), 1);
        step();
        at("R6 i3", S_I, 2'd3);
        chk("R6 ar", 32'(ar), 32'h300);
        step();
        at("R6 to dir", S_D, 2'd0);
        step();
        chk("R7 addr", 32'(mem_addr), 32'h300);
        step(); step();
        at("R7 exec", S_E, 2'd0);
        chk("R7 mbr", 32'(mem_wdata), 32'h1234);
    endtask

    task automatic t_class(input logic [1:0] m, input logic [3:0] op,
                           input logic r, input logic io);
        restart({m, op, 10'h001});
        to_fetch_t3();
        chk("R11 is_rri", 32'(is_rri), 32'(r));
        chk("R11 is_ioi", 32'(is_ioi), 32'(io));
        step();
        at("R5 class->exec", S_E, 2'd0);
    endtask

    task automatic t_multi();
        restart({2'b00, 4'h5, 10'h00A});
        exec_long = 1'b1;
        to_fetch_t3();
        step();
        at("R8 e0", S_E, 2'd0);
        step();
        at("R8 e1 held", S_E, 2'd1);
        step();
        at("R8 e2", S_E, 2'd2);
        exec_done = 1'b1;
        step();
        exec_done = 1'b0;
        exec_long = 1'b0;
        at("R8 done->fetch", S_F, 2'd0);
    endtask

    task automatic t_interrupt();
        restart({2'b00, 4'h2, 10'h033});
        int_req = 1'b1;
        to_fetch_t3();
        step();
        at("R9 exec", S_E, 2'd0);
        step();
        at("R9 intr", S_X, 2'd0);
        chk("R10 int_ack", 32'(int_ack), 1);
        step();
        int_req = 1'b0;
        chk("R10 mbr=pc", 32'(mem_wdata), 1);
        chk("R10 pc_clr", 32'(pc_clr), 1);
        step();
        chk("R10 wr", 32'(mem_wr), 1);
        chk("R10 wr addr", 32'(mem_addr), 0);
        chk("R10 pc cleared", 32'(pc), 0);
        step();
        at("R10 x3", S_X, 2'd3);
        chk("R10 pc=1", 32'(pc), 1);
        chk("R10 saved", 32'(mem[0]), 1);
        step();
        at("R10 fetch", S_F, 2'd0);
        chk("R10 resume", 32'(pc), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_immediate();
        t_direct();
        t_indirect();
        t_class(2'b00, 4'hF, 1'b1, 1'b0);
        t_class(2'b11, 4'hF, 1'b0, 1'b1);
        t_class(2'b10, 4'h4, 1'b0, 1'b0);
        t_multi();
        t_interrupt();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end
endmodule